// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that paces itself from a single-cycle tick-enable input, which stands in for the instruction-rate clock. A selectable prescaler turns every 1, 4 or 16 ticks into one counter step. The counter climbs from zero until it equals a programmable period value. On the next step it returns to zero, and that step is called a match.

Each match raises a one-cycle time-base pulse that a PWM generator can follow. Matches also feed a postscaler. After a programmed number of matches, the postscaler sets a sticky interrupt flag. The flag, masked by an enable bit, drives the interrupt request.

Software reaches the counter, period, control and interrupt registers through a small synchronous write / combinational read bus with a 2-bit address.

Top module: `pmtimer`

## Requirements
- R1: When a prescaled step occurs, the counter goes up by one if it differs from the period value. If it equals the period value, the counter returns to 0 and a match occurs.
- R2: The period register (address 1) can be written and read back, and it resets to FFh.
- R3: Control bits 1:0 select the prescale. 00 gives one counter step per tick, 01 gives one step per 4 ticks, and 10 or 11 gives one step per 16 ticks.
- R4: When control bits 6:3 hold N, the interrupt flag (address 3 bit 0) is set on every (N+1)th match.
- R5: `tb_pulse` is high for exactly the cycle after each match, whatever the postscale setting, and the counter reads 0 during that cycle.
- R6: While control bit 2 (run) is 0, ticks have no effect: the counter and both scaler counts hold their values.
- R7: A write to the counter (address 0) or to the control register (address 2) restarts the prescaler and postscaler counts. Such a write leaves the period register unchanged.
- R8: Once set, the interrupt flag stays set until software writes 0 to address 3 bit 0. Address 3 bit 1 is the interrupt enable, and `irq` is high exactly when both the flag and the enable are 1.
- R9: If a counter write and a prescaled step fall in the same cycle, the written value is loaded and the step is dropped.
- R10: Control bit 7 always reads 0. After reset, the counter, control and interrupt registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable strobe at the instruction rate |
| bus_addr | input | 2 | Register select: 0 counter, 1 period, 2 control, 3 interrupt |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| tb_pulse | output | 1 | One-cycle time-base pulse following each period match |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
Assertions check several rules on every cycle: the counter's step and wrap rule, the precedence of a counter write, the bounds of the prescaler and postscaler counts, the hold while stopped, and the stickiness of the flag. They also check that each time-base pulse coincides with a zero count. The bench scenarios are what show the exact division ratios for each prescale code, and that a flag appears on the (N+1)th match rather than the Nth. Only the scenarios can show that a register write restarts a partly filled scaler, because that is visible only as a delayed step or flag at the ports.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_PERIOD = 2'd1,
      REG_CTRL   = 2'd2,
      REG_IRQ    = 2'd3
   } pmt_reg_e;

   // control register layout
   localparam int CTRL_PRE_LSB = 0;
   localparam int CTRL_RUN_BIT = 2;
   localparam int CTRL_PS_LSB  = 3;

   // interrupt register layout
   localparam int IRQ_FLAG_BIT = 0;
   localparam int IRQ_EN_BIT   = 1;

endpackage

// File: rtl/pmt_prescale.sv
module pmt_prescale #(
   parameter int STEP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       adv,
   input  logic [1:0] sel,
   output logic       step
);
   localparam int PRE_W = 2 * STEP_LOG2;
   localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << STEP_LOG2) - 1);
   localparam logic [PRE_W-1:0] LIM_MAX = PRE_W'((1 << PRE_W) - 1);

   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("pmt_prescale: STEP_LOG2 must be at least 1");
   end

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] limit;
   logic             last;

   always_comb begin
      if (sel[1])      limit = LIM_MAX;
      else if (sel[0]) limit = LIM_MID;
      else             limit = '0;
   end

   assign last = (pre_cnt == limit);
   assign step = adv && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_cnt <= '0;
      else if (clr)     pre_cnt <= '0;
      else if (adv)     pre_cnt <= last ? '0 : pre_cnt + 1'b1;
   end

   // the selection only changes with a clear, so the count never passes its limit
   assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= limit);

   assert_pre_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(pre_cnt));

endmodule

// File: rtl/pmt_postscale.sv
module pmt_postscale #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          match,
   input  logic [CW-1:0] ratio,
   output logic          fire
);
   if (CW < 1) begin : g_bad_cw
      $error("pmt_postscale: CW must be at least 1");
   end

   logic [CW-1:0] post_cnt;

   assign fire = match && (post_cnt == ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      post_cnt <= '0;
      else if (clr)    post_cnt <= '0;
      else if (match)  post_cnt <= fire ? '0 : post_cnt + 1'b1;
   end

   assert_post_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      post_cnt <= ratio);

   assert_post_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (post_cnt == '0));

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             match
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   assign at_top = (cnt_q == period);
   assign match  = step && !load && at_top;
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (step)   cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cnt_q == period) |=> (cnt_q == '0));

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cnt_q != period) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pmtimer.sv
module pmtimer #(
   parameter int CNT_W     = 8,
   parameter int POST_W    = 4,
   parameter int STEP_LOG2 = 2,
   parameter bit REG_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             tb_pulse,
   output logic             irq
);
   import pmt_pkg::*;

   localparam int PS_MSB = CTRL_PS_LSB + POST_W - 1;

   if (POST_W < 1 || PS_MSB >= CNT_W) begin : g_bad_layout
      $error("pmtimer: postscale field does not fit the data width");
   end

   // ---------------- registers ----------------
   logic [CNT_W-1:0]  period_q;
   logic              run_q;
   logic [1:0]        pre_sel_q;
   logic [POST_W-1:0] post_q;
   logic              flag_q;
   logic              en_q;

   logic wr_cnt, wr_per, wr_ctrl, wr_irq;
   logic clr_scalers, adv, step, match, fire;
   logic [CNT_W-1:0] count;

   assign wr_cnt  = bus_wr && (bus_addr == REG_COUNT);
   assign wr_per  = bus_wr && (bus_addr == REG_PERIOD);
   assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
   assign wr_irq  = bus_wr && (bus_addr == REG_IRQ);

   assign clr_scalers = wr_cnt || wr_ctrl;
   assign adv         = tick && run_q && !clr_scalers;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q  <= '1;
         run_q     <= 1'b0;
         pre_sel_q <= '0;
         post_q    <= '0;
      end else begin
         if (wr_per) period_q <= bus_wdata;
         if (wr_ctrl) begin
            run_q     <= bus_wdata[CTRL_RUN_BIT];
            pre_sel_q <= bus_wdata[CTRL_PRE_LSB +: 2];
            post_q    <= bus_wdata[CTRL_PS_LSB +: POST_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (fire)        flag_q <= 1'b1;
         else if (wr_irq) flag_q <= bus_wdata[IRQ_FLAG_BIT];
         if (wr_irq)      en_q   <= bus_wdata[IRQ_EN_BIT];
      end
   end

   assign irq = flag_q && en_q;

   // ---------------- datapath ----------------
   pmt_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_scalers),
      .adv   (adv),
      .sel   (pre_sel_q),
      .step  (step)
   );

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .load     (wr_cnt),
      .load_val (bus_wdata),
      .period   (period_q),
      .count    (count),
      .match    (match)
   );

   pmt_postscale #(.CW(POST_W)) u_post (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_scalers),
      .match (match),
      .ratio (post_q),
      .fire  (fire)
   );

   // ---------------- time-base pulse ----------------
   if (REG_PULSE) begin : g_reg_pulse
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= match;
      end
      assign tb_pulse = pulse_q;

      assert_pulse_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_q |-> (count == '0));
   end else begin : g_comb_pulse
      assign tb_pulse = match;
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_COUNT:  bus_rdata = count;
         REG_PERIOD: bus_rdata = period_q;
         REG_CTRL: begin
            bus_rdata[CTRL_PRE_LSB +: 2]      = pre_sel_q;
            bus_rdata[CTRL_RUN_BIT]           = run_q;
            bus_rdata[CTRL_PS_LSB +: POST_W]  = post_q;
         end
         default: begin
            bus_rdata[IRQ_FLAG_BIT] = flag_q;
            bus_rdata[IRQ_EN_BIT]   = en_q;
         end
      endcase
   end

   // ---------------- assertions ----------------
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_cnt) |=> $stable(count));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_irq) |=> flag_q);

   assert_period_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_scalers && !wr_per) |=> $stable(period_q));

endmodule

// File: tb/sim_pmtimer.sv
`timescale 1ns/1ps
module sim_pmtimer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tb_pulse;
   logic       irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      int         kind;   // 0 register read, 1 time-base pulse, 2 irq
      logic [7:0] exp;
      string      req;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   pmtimer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tb_pulse  (tb_pulse),
      .irq       (irq)
   );

   // monitor: compares one expected item per falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t it;
         logic [7:0] act;
         it = sb.pop_front();
         case (it.kind)
            0:       act = bus_rdata;
            1:       act = {7'b0, tb_pulse};
            default: act = {7'b0, irq};
         endcase
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      cyc();
      bus_wr    = 1'b0;
   endtask

   task automatic expect_item(input int kind, input logic [1:0] a, input logic [7:0] v, input string req);
      exp_t it;
      bus_addr = a;
      it.kind = kind;
      it.exp  = v;
      it.req  = req;
      sb.push_back(it);
      cyc();
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) cyc();
      tick = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc();

      // R10 / R2: reset state
      expect_item(0, 2'd0, 8'h00, "R10 counter reset");
      expect_item(0, 2'd1, 8'hFF, "R2 period reset");
      expect_item(0, 2'd2, 8'h00, "R10 control reset");
      expect_item(0, 2'd3, 8'h00, "R10 irq reg reset");
      expect_item(2, 2'd0, 8'h00, "R8 irq low at reset");

      // R2 / R1: count and wrap with period 3, prescale 1:1
      wr(2'd1, 8'h03);
      expect_item(0, 2'd1, 8'h03, "R2 period readback");
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h04);
      ticks(2);
      expect_item(0, 2'd0, 8'h02, "R1 counts up");
      ticks(2);
      expect_item(0, 2'd0, 8'h00, "R1 wraps after period");
      expect_item(0, 2'd3, 8'h01, "R4 flag on each match with N=0");
      expect_item(2, 2'd0, 8'h00, "R8 irq masked while disabled");
      expect_item(0, 2'd3, 8'h01, "R8 flag sticky");
      wr(2'd3, 8'h03);
      expect_item(2, 2'd0, 8'h01, "R8 irq with flag and enable");
      wr(2'd3, 8'h02);
      expect_item(0, 2'd3, 8'h02, "R8 flag cleared, enable kept");
      expect_item(2, 2'd0, 8'h00, "R8 irq drops after clear");

      // R5: time-base pulse after a wrap
      wr(2'd0, 8'h03);
      tick = 1'b1;
      expect_item(1, 2'd0, 8'h00, "R5 no pulse before match");
      tick = 1'b0;
      expect_item(1, 2'd0, 8'h01, "R5 pulse after match");
      expect_item(1, 2'd0, 8'h00, "R5 pulse lasts one cycle");
      wr(2'd3, 8'h00);

      // R3: prescale 1:4 and 1:16
      wr(2'd2, 8'h05);
      wr(2'd0, 8'h00);
      ticks(8);
      expect_item(0, 2'd0, 8'h02, "R3 divide by 4");
      wr(2'd2, 8'h06);
      wr(2'd0, 8'h00);
      ticks(15);
      expect_item(0, 2'd0, 8'h00, "R3 divide by 16 not yet");
      ticks(1);
      expect_item(0, 2'd0, 8'h01, "R3 divide by 16 step");

      // R4: postscale N=2 -> flag on third match
      wr(2'd2, 8'h14);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      ticks(2);
      expect_item(0, 2'd3, 8'h00, "R4 no flag after two matches");
      ticks(1);
      expect_item(0, 2'd3, 8'h01, "R4 flag on third match");

      // R6: stopped timer ignores ticks
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h05);
      ticks(5);
      expect_item(0, 2'd0, 8'h05, "R6 hold while stopped");

      // R7: control write restarts prescaler
      wr(2'd2, 8'h05);
      wr(2'd0, 8'h00);
      ticks(3);
      wr(2'd2, 8'h05);
      ticks(1);
      expect_item(0, 2'd0, 8'h00, "R7 prescaler restarted by control write");
      expect_item(0, 2'd1, 8'hFF, "R7 period unchanged");

      // R7: counter write restarts postscaler (N=1)
      wr(2'd2, 8'h0C);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      ticks(1);
      wr(2'd0, 8'h00);
      ticks(1);
      expect_item(0, 2'd3, 8'h00, "R7 postscaler restarted by counter write");
      ticks(1);
      expect_item(0, 2'd3, 8'h01, "R7 flag after two fresh matches");

      // R9: counter write beats a step
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h04);
      wr(2'd0, 8'h00);
      tick = 1'b1;
      wr(2'd0, 8'h40);
      tick = 1'b0;
      expect_item(0, 2'd0, 8'h40, "R9 write wins over step");

      // R10: bit 7 of control reads 0
      wr(2'd2, 8'hFF);
      expect_item(0, 2'd2, 8'h7F, "R10 control bit 7 reads 0");

      cyc();
      cyc();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule